// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a short burst into a synchronous memory. A load cycle captures a full start address. After that, each advance cycle moves to the next beat. The upper address bits stay as loaded. Only the low bits step through the burst, and the order they take is set by a static mode input.

In interleaved order, each beat's low bits are the start bits XORed with the beat number. In linear order, the start bits are incremented and wrap within the burst. An active-high stall input freezes the whole sequencer: while it is high, both the advance/load control and the start address are ignored.

The design keeps only the loaded start address and a beat counter. The output address and the beat index are derived from these two registers. A burst that keeps advancing past its last beat wraps around and repeats the same sequence.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and until the first accepted load, `burst_addr` and `beat_idx` are all zeros.
- R2: A clock edge with `stall`=0 and `adv`=0 is a load. From the next cycle on, `burst_addr` equals the `start_addr` sampled at that edge and `beat_idx` is 0.
- R3: A clock edge with `stall`=0 and `adv`=1 is an advance. From the next cycle on, `beat_idx` is the previous `beat_idx` plus 1, modulo 4.
- R4: When `mode_ilv`=1 (interleaved), the low two bits of `burst_addr` equal the loaded start's low two bits XOR `beat_idx`. For example, a start of 2 gives the beats 2, 3, 0, 1.
- R5: When `mode_ilv`=0 (linear), the low two bits of `burst_addr` equal the loaded start's low two bits plus `beat_idx`, modulo 4. For example, a start of 1 gives the beats 1, 2, 3, 0.
- R6: Bits above the low two bits of `burst_addr` keep the loaded value through every advance.
- R7: On a clock edge with `stall`=1, the edge has no effect. `burst_addr` and `beat_idx` stay the same whatever `adv` and `start_addr` are.
- R8: After four advances, `beat_idx` returns to 0 and `burst_addr` returns to the loaded start. Further advances repeat the same four-beat sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stall | input | 1 | 1 freezes the sequencer for this edge |
| adv | input | 1 | 0 loads `start_addr`, 1 advances one beat |
| mode_ilv | input | 1 | Static order select: 1 interleaved, 0 linear |
| start_addr | input | ADDR_W (20) | External start address |
| burst_addr | output | ADDR_W (20) | Address of the current beat |
| beat_idx | output | CNT_W (2) | Number of the current beat within the burst |

## Verification
The bench sweeps both orderings and all four start offsets. Each start address carries a distinct upper pattern, so a mix-up between the XOR and add mappings shows up at a specific beat, and an upper-bit disturbance is caught. Each burst advances seven times, which crosses the wrap point; this separates a correct wrap from a counter that sticks or saturates. Stalled edges carry both a load request and an advance request with new address values, so a stall path that leaks either action is exposed. Advances that resume after a stall then confirm that no beat was lost or skipped.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    BSQ_HOLD = 2'd0,
    BSQ_LOAD = 2'd1,
    BSQ_STEP = 2'd2
  } bsq_op_e;

  function automatic bsq_op_e bsq_decode(input logic stall, input logic adv);
    if (stall)    return BSQ_HOLD;
    else if (adv) return BSQ_STEP;
    else          return BSQ_LOAD;
  endfunction
endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter
  import bsq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bsq_op_e          op,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    case (op)
      BSQ_LOAD: cnt_d = '0;
      BSQ_STEP: cnt_d = cnt_q + 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bsq_op_e           op,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic              base_en;

  assign base_en = (op == BSQ_LOAD);

  always_comb begin
    base_d = base_q;
    if (base_en) base_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign q = base_q;
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
  parameter int CNT_W = 2
) (
  input  logic             mode_ilv,
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] beat_lo
);
  logic [CNT_W-1:0] ilv_lo;
  logic [CNT_W-1:0] lin_lo;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
    assign ilv_lo[b] = start_lo[b] ^ cnt[b];
  end

  assign lin_lo  = start_lo + cnt;
  assign beat_lo = mode_ilv ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int CNT_W     = 2,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              adv,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [CNT_W-1:0]  beat_idx
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic              core_rst_n;
  bsq_op_e           op;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  beat_lo;

  bsq_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  assign op = bsq_decode(stall, adv);

  bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk   (clk),
    .rst_n (core_rst_n),
    .op    (op),
    .d     (start_addr),
    .q     (base)
  );

  bsq_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (core_rst_n),
    .op    (op),
    .cnt   (cnt)
  );

  bsq_order_map #(.CNT_W(CNT_W)) u_map (
    .mode_ilv (mode_ilv),
    .start_lo (base[CNT_W-1:0]),
    .cnt      (cnt),
    .beat_lo  (beat_lo)
  );

  assign burst_addr = {base[ADDR_W-1 -: HI_W], beat_lo};
  assign beat_idx   = cnt;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              adv,
  input logic              mode_ilv,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [CNT_W-1:0]  beat_idx
);
  AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv) |=> (burst_addr == $past(start_addr) && beat_idx == '0)); // R2

  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv) |=> (beat_idx == CNT_W'($past(beat_idx) + 1'b1))); // R3

  AST_ILV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ilv && !stall && adv) |=> (!mode_ilv ||
      ((burst_addr[CNT_W-1:0] ^ $past(burst_addr[CNT_W-1:0])) ==
       (beat_idx ^ $past(beat_idx))))); // R4

  AST_LIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ilv && !stall && adv) |=> (mode_ilv ||
      (burst_addr[CNT_W-1:0] == CNT_W'($past(burst_addr[CNT_W-1:0]) + 1'b1)))); // R5

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv) |=> (burst_addr[ADDR_W-1:CNT_W] == $past(burst_addr[ADDR_W-1:CNT_W]))); // R6

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(burst_addr) && $stable(beat_idx))); // R7
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .adv        (adv),
  .mode_ilv   (mode_ilv),
  .start_addr (start_addr),
  .burst_addr (burst_addr),
  .beat_idx   (beat_idx)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 20;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall;
  logic          adv;
  logic          mode_ilv;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] burst_addr;
  logic [CW-1:0] beat_idx;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .adv        (adv),
    .mode_ilv   (mode_ilv),
    .start_addr (start_addr),
    .burst_addr (burst_addr),
    .beat_idx   (beat_idx)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic a, input logic [AW-1:0] addr);
    @(negedge clk);
    stall      = s;
    adv        = a;
    start_addr = addr;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] exp_lo(input logic m, input logic [1:0] s, input logic [1:0] k);
    return m ? (s ^ k) : 2'((s + k) & 2'd3);
  endfunction

  initial begin
    rst_n = 1'b0; stall = 1'b1; adv = 1'b0; mode_ilv = 1'b1; start_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr in reset", burst_addr, '0);
    chk("R1 idx in reset", AW'(beat_idx), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b1, 1'b1, 20'hFFFFF);
    chk("R1 addr after release", burst_addr, '0);
    chk("R1 idx after release", AW'(beat_idx), '0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] base;
        base = AW'((s * 131 + m * 977 + 32'h2A5C3) << 2) | AW'(s);
        @(negedge clk);
        mode_ilv = m[0];
        step(1'b0, 1'b0, base);
        chk("R2 load addr", burst_addr, base);
        chk("R2 load idx", AW'(beat_idx), '0);
        for (int k = 1; k < 8; k++) begin
          logic [AW-1:0] e;
          e = {base[AW-1:2], exp_lo(m[0], 2'(s), 2'(k))};
          step(1'b0, 1'b1, ~base);
          chk("R3 beat index", AW'(beat_idx), AW'(k % 4));
          if (m == 1) chk("R4 interleaved beat", burst_addr, e);
          else        chk("R5 linear beat", burst_addr, e);
          chk("R6 upper bits", AW'(burst_addr[AW-1:2]), AW'(base[AW-1:2]));
          if (k == 4) chk("R8 wrap to start", burst_addr, base);
        end
        // beat index now 3; stall with load and with advance requests
        step(1'b1, 1'b0, ~base);
        chk("R7 stall ignores load", burst_addr, {base[AW-1:2], exp_lo(m[0], 2'(s), 2'd3)});
        step(1'b1, 1'b1, ~base);
        chk("R7 stall ignores advance idx", AW'(beat_idx), AW'(3));
        step(1'b0, 1'b1, ~base);
        chk("R8 resume wraps after stall", burst_addr, base);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule